// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches four maskable external interrupt pins and one non-maskable interrupt pin. Each pin passes through a two-flop synchroniser before detection. Each maskable channel has its own 2-bit detection mode, chosen from low level, high level, rising edge and falling edge. A detected event sets a sticky request flag for that channel. An enable mask gates the flags into a single combined interrupt output. Software reaches a mode register, the flag register and the mask register through a small register port.

The non-maskable input has no programmable mode. In normal operation a falling edge triggers it. While the stop-mode input is high, a low level triggers it instead, so a part whose clock logic is idling can still be woken. The non-maskable request sits in its own flag, and the CPU clears that flag with an acknowledge pulse.

In either level mode, clearing a flag while the pin is still at its active level does not stick. The flag sets again in the next cycle, so software must remove the cause before the request goes away. Changing a channel's mode never creates an edge by itself, because the edge history follows the pin in every mode.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset the mode register reads 0x00, the flag and mask registers read 0, and irq_out and nmi_req are low.
- R2: The mode register (reg_sel 0) is read/write. Channel n is controlled by bits [2n+1:2n]. Flags are read at reg_sel 1 and the mask at reg_sel 2, both in bits [3:0], one bit per channel.
- R3: Mode code 00 detects a low level, 01 a high level, 10 a rising edge and 11 a falling edge. A pin change shows in the flag at the third rising clock edge after it.
- R4: In a level mode, writing 0 to a flag while the synchronised pin is still at its active level leaves the flag set.
- R5: In an edge mode, a cleared flag stays clear while the pin holds steady.
- R6: A flag write (reg_sel 1) clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A detection in the same cycle wins over the clear.
- R7: irq_out is high exactly when some channel has both its flag and its mask bit set. Clearing a mask bit leaves the flag unchanged.
- R8: Outside stop mode, a falling edge on nmi_n sets nmi_req three clock edges later. A held low level or a rising edge does not set it again after an acknowledge.
- R9: While stop_mode is high, a low level on nmi_n sets nmi_req, and an acknowledge during that low level does not clear it.
- R10: Writing a new mode while the pin is steady sets no flag in the edge modes.
- R11: A one-cycle nmi_ack clears nmi_req when no detection occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 flags, 2 mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_in | input | 4 | Maskable interrupt pins, asynchronous |
| nmi_n | input | 1 | Non-maskable interrupt pin, asynchronous |
| stop_mode | input | 1 | Stop mode: NMI is detected as a low level |
| nmi_ack | input | 1 | Clear pulse for the NMI request |
| irq_out | output | 1 | Combined maskable request |
| nmi_req | output | 1 | Non-maskable request |

## Verification
A vector table drives each of the four mode codes on rotating channels, with one pin transition that should trigger and one that should not. This separates level sensitivity from edge sensitivity and polarity from polarity, and it checks the bit-pair mapping because the other flags must stay clear. Directed sequences cover the exact three-edge latency, a clear while the level is still active against a clear after an edge, write-one masking, gating by the mask, mode rewrites on a quiet pin, and the switch of the NMI between edge and level detection under stop mode.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_mode_e;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_FLAG = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
endpackage

// File: rtl/eirq_sync.sv
// Two-stage synchroniser for asynchronous pins.
module eirq_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/eirq_chan.sv
// One maskable channel: edge history and mode-selected detection.
module eirq_chan
  import eirq_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic [1:0] mode,
  output logic       hit
);
  logic prev_q;

  // History follows the pin in every mode, so a mode write makes no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= pin_s;
  end

  always_comb begin
    unique case (det_mode_e'(mode))
      DET_LOW:  hit = ~pin_s;
      DET_HIGH: hit = pin_s;
      DET_RISE: hit = pin_s & ~prev_q;
      DET_FALL: hit = ~pin_s & prev_q;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/eirq_flags.sv
// Sticky request flags: write-zero-to-clear, detection wins.
module eirq_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         clr_en,
  input  logic [N-1:0] keep,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_d;

  always_comb begin
    flags_d = flags;
    if (clr_en) flags_d = flags_d & keep;
    flags_d = flags_d | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end
endmodule

// File: rtl/eirq_nmi.sv
// Non-maskable request: falling edge normally, low level in stop mode.
module eirq_nmi (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_s,
  input  logic stop_mode,
  input  logic ack,
  output logic hit,
  output logic req
);
  logic prev_q;
  logic req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= nmi_s;
  end

  always_comb begin
    hit   = stop_mode ? ~nmi_s : (prev_q & ~nmi_s);
    req_d = (req & ~ack) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_d;
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import eirq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int MODE_W = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [MODE_W-1:0] reg_wdata,
  output logic [MODE_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    irq_in,
  input  logic              nmi_n,
  input  logic              stop_mode,
  input  logic              nmi_ack,
  output logic              irq_out,
  output logic              nmi_req
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [NCH-1:0]    enables, enables_d;
  logic [NCH-1:0]    irq_s;
  logic [NCH-1:0]    hits;
  logic [NCH-1:0]    flags;
  logic              nmi_s;
  logic              nmi_hit;
  logic              wr_mode, wr_flag, wr_mask;
  logic              unused_wdata;

  assign wr_mode = reg_wr && (reg_sel == SEL_MODE);
  assign wr_flag = reg_wr && (reg_sel == SEL_FLAG);
  assign wr_mask = reg_wr && (reg_sel == SEL_MASK);
  assign unused_wdata = ^reg_wdata[MODE_W-1:NCH];

  eirq_sync #(.W(NCH), .RST_VAL({NCH{1'b1}})) u_sync_irq (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(irq_s)
  );

  eirq_sync #(.W(1), .RST_VAL(1'b1)) u_sync_nmi (
    .clk(clk), .rst_n(rst_n), .d(nmi_n), .q(nmi_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    eirq_chan #(.RST_VAL(1'b1)) u_chan (
      .clk(clk), .rst_n(rst_n), .pin_s(irq_s[c]),
      .mode(mode_q[2*c+1 -: 2]), .hit(hits[c])
    );
  end

  eirq_flags #(.N(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit(hits), .clr_en(wr_flag),
    .keep(reg_wdata[NCH-1:0]), .flags(flags)
  );

  eirq_nmi u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_s(nmi_s), .stop_mode(stop_mode),
    .ack(nmi_ack), .hit(nmi_hit), .req(nmi_req)
  );

  always_comb begin
    mode_d    = wr_mode ? reg_wdata : mode_q;
    enables_d = wr_mask ? reg_wdata[NCH-1:0] : enables;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      enables <= '0;
    end else begin
      mode_q  <= mode_d;
      enables <= enables_d;
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_MODE: reg_rdata = mode_q;
      SEL_FLAG: reg_rdata = {{(MODE_W-NCH){1'b0}}, flags};
      SEL_MASK: reg_rdata = {{(MODE_W-NCH){1'b0}}, enables};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_out = |(flags & enables);
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [1:0]     reg_sel,
  input logic [NCH-1:0] wdata_lo,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] hits,
  input logic [NCH-1:0] enables,
  input logic           irq_out,
  input logic           nmi_s,
  input logic           nmi_hit,
  input logic           stop_mode,
  input logic           nmi_ack,
  input logic           nmi_req
);
  logic flag_wr;
  assign flag_wr = reg_wr && (reg_sel == 2'd1);

  // R4 / R6: a detection always lands in the flag the next cycle
  assert_detect_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(hits)) == $past(hits)));

  // R6: writing ones never clears a flag
  assert_write_one_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && (wdata_lo == {NCH{1'b1}})) |=> (($past(flags) & ~flags) == '0));

  // R5: with no write and no detection, flags hold
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && (hits == '0)) |=> $stable(flags));

  // R7: no enable, no combined request
  assert_mask_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enables == '0) |-> !irq_out);

  // R9: low level in stop mode raises the NMI request
  assert_stop_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !nmi_s) |=> nmi_req);

  // R11: acknowledge without a detection clears the NMI request
  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !nmi_hit) |=> !nmi_req);
endmodule

bind ext_irq_detect eirq_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .wdata_lo(reg_wdata[NCH-1:0]), .flags(flags), .hits(hits),
  .enables(enables), .irq_out(irq_out), .nmi_s(nmi_s), .nmi_hit(nmi_hit),
  .stop_mode(stop_mode), .nmi_ack(nmi_ack), .nmi_req(nmi_req)
);

// File: tb/ext_irq_detect_test.sv
`timescale 1ns/1ps
module ext_irq_detect_test;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] irq_in;
  logic       nmi_n;
  logic       stop_mode;
  logic       nmi_ack;
  logic       irq_out;
  logic       nmi_req;

  int checks = 0;
  int fails  = 0;

  ext_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .nmi_n(nmi_n), .stop_mode(stop_mode), .nmi_ack(nmi_ack),
    .irq_out(irq_out), .nmi_req(nmi_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {channel[1:0], mode[1:0], pre, post, expect}
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 2'b00, 1'b1, 1'b0, 1'b1},
    {2'd1, 2'b00, 1'b1, 1'b1, 1'b0},
    {2'd2, 2'b01, 1'b0, 1'b1, 1'b1},
    {2'd3, 2'b01, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'b10, 1'b0, 1'b1, 1'b1},
    {2'd1, 2'b10, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'b11, 1'b1, 1'b0, 1'b1},
    {2'd3, 2'b11, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] data);
    reg_sel = sel;
    #0.5 data = reg_rdata;
  endtask

  task automatic ack_pulse;
    nmi_ack = 1'b1;
    cyc(1);
    nmi_ack = 1'b0;
  endtask

  task automatic quiet;
    irq_in = 4'hF;
    wr(2'd0, 8'h00);
    cyc(5);
    wr(2'd1, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    irq_in = 4'hF; nmi_n = 1'b1; stop_mode = 1'b0; nmi_ack = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd(2'd0, v); check("R1 mode", v, 8'h00);
    rd(2'd1, v); check("R1 flags", v, 8'h00);
    rd(2'd2, v); check("R1 mask", v, 8'h00);
    check("R1 irq_out", {7'd0, irq_out}, 8'h00);
    check("R1 nmi_req", {7'd0, nmi_req}, 8'h00);

    // R2 read/write of the mode register
    wr(2'd0, 8'hA5);
    rd(2'd0, v); check("R2 mode readback", v, 8'hA5);
    quiet();

    // R3 table of modes on rotating channels
    foreach (VEC[i]) begin
      automatic logic [1:0] ch  = VEC[i][6:5];
      automatic logic [1:0] md  = VEC[i][4:3];
      automatic logic       pre = VEC[i][2];
      automatic logic       pst = VEC[i][1];
      automatic logic       ex  = VEC[i][0];
      irq_in[ch] = pre;
      wr(2'd0, 8'(md) << (2 * ch));
      cyc(5);
      wr(2'd1, 8'h00);
      irq_in[ch] = pst;
      cyc(3);
      rd(2'd1, v);
      check($sformatf("R3 vector %0d mode %b ch %0d", i, md, ch), v, 8'(ex) << ch);
      quiet();
    end

    // R3 exact latency: third edge after the pin change
    wr(2'd0, 8'h04);
    irq_in[1] = 1'b0;
    cyc(5);
    wr(2'd1, 8'h00);
    irq_in[1] = 1'b1;
    cyc(2);
    rd(2'd1, v); check("R3 latency two edges", v, 8'h00);
    cyc(1);
    rd(2'd1, v); check("R3 latency three edges", v, 8'h02);
    quiet();

    // R4 level mode: clear while active does not stick
    irq_in[0] = 1'b0;
    wr(2'd0, 8'h01);
    irq_in[0] = 1'b1;
    cyc(4);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R4 clear while active", v, 8'h01);
    irq_in[0] = 1'b0;
    cyc(4);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R4 clear after release", v, 8'h00);
    quiet();

    // R5 edge mode: cleared flag stays clear
    irq_in[3] = 1'b0;
    wr(2'd0, 8'h80);
    cyc(5);
    wr(2'd1, 8'h00);
    irq_in[3] = 1'b1;
    cyc(4);
    rd(2'd1, v); check("R5 rising edge sets", v, 8'h08);
    wr(2'd1, 8'h00);
    cyc(4);
    rd(2'd1, v); check("R5 stays clear", v, 8'h00);
    quiet();

    // R6 writing ones sets nothing
    wr(2'd1, 8'h0F);
    rd(2'd1, v); check("R6 write ones on clear flags", v, 8'h00);

    // R7 / R6 mask gating on channel 2 falling edge
    wr(2'd0, 8'h30);
    cyc(3);
    irq_in[2] = 1'b0;
    cyc(4);
    rd(2'd1, v); check("R7 flag set", v, 8'h04);
    check("R7 masked off", {7'd0, irq_out}, 8'h00);
    wr(2'd1, 8'h0F);
    rd(2'd1, v); check("R6 write ones keeps flag", v, 8'h04);
    wr(2'd2, 8'h04);
    check("R7 enabled", {7'd0, irq_out}, 8'h01);
    wr(2'd2, 8'h0B);
    check("R7 other enables", {7'd0, irq_out}, 8'h00);
    rd(2'd1, v); check("R7 flag kept after mask", v, 8'h04);
    wr(2'd1, 8'h0B);
    rd(2'd1, v); check("R6 zero bit clears", v, 8'h00);
    wr(2'd2, 8'h00);
    quiet();

    // R10 mode writes on quiet pins
    wr(2'd0, 8'hAA);
    cyc(4);
    rd(2'd1, v); check("R10 switch to rising", v, 8'h00);
    wr(2'd0, 8'hFF);
    cyc(4);
    rd(2'd1, v); check("R10 switch to falling", v, 8'h00);
    quiet();

    // R8 NMI falling edge in normal mode
    nmi_n = 1'b0;
    cyc(2);
    check("R8 nmi two edges", {7'd0, nmi_req}, 8'h00);
    cyc(1);
    check("R8 nmi three edges", {7'd0, nmi_req}, 8'h01);
    ack_pulse();
    check("R11 ack clears", {7'd0, nmi_req}, 8'h00);
    cyc(4);
    check("R8 held low no retrigger", {7'd0, nmi_req}, 8'h00);
    nmi_n = 1'b1;
    cyc(4);
    check("R8 rising ignored", {7'd0, nmi_req}, 8'h00);

    // R9 stop mode: level detection
    stop_mode = 1'b1;
    nmi_n = 1'b0;
    cyc(4);
    check("R9 stop low sets", {7'd0, nmi_req}, 8'h01);
    ack_pulse();
    check("R9 ack while low", {7'd0, nmi_req}, 8'h01);
    nmi_n = 1'b1;
    cyc(4);
    ack_pulse();
    check("R11 ack after release", {7'd0, nmi_req}, 8'h00);
    stop_mode = 1'b0;
    cyc(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule